// File: doc/BRIEF.md
# Free-Partition Header Formatter

This block lays down an empty-partition header at the bottom of a byte-addressed non-volatile store. It does so through a one-byte-per-cycle write port. A single-cycle start pulse, sampled together with a 16-bit partition length, launches the sequence. The block then emits the sixteen header bytes in ascending address order. While it emits them it folds each byte into a running sum. It finishes by overwriting the checksum slot with the folded result.

The header holds four parts: a marker byte, a checksum slot, the length in big-endian order, and a twelve-character filler name. The checksum is the end-around-carry byte sum of all sixteen bytes, with the checksum slot itself counted as zero. A one-cycle done pulse marks completion. The block ignores further start pulses until it is idle again. The header is placed at a parameterised base address, which is zero by default.

Top module: `nvhdr_formatter`

## Requirements
- R1: After synchronous reset the block is idle: `wr_en_o`, `done_o` and `busy_o` are all low.
- R2: A start pulse seen while idle produces sixteen writes in the sixteen consecutive cycles that follow, to header offsets 0 to 15 in ascending order (address = BASE_ADDR + offset).
- R3: Offset 0 receives the marker value 0x7F, and the first write to offset 1 carries 0x00.
- R4: Offset 2 receives bits 15:8 and offset 3 receives bits 7:0 of the length that was present on the start cycle; later changes on `length_i` have no effect.
- R5: Offsets 4 to 15 each receive 0x77.
- R6: In the cycle right after the sixteenth write, a seventeenth write goes to offset 1. It carries the checksum C = ((S mod 256) + floor(S / 256)) mod 256, where S is the integer sum of the sixteen bytes already written (offset 1 counted as 0x00).
- R7: `done_o` is high for exactly the one cycle after the checksum write. In that cycle `wr_en_o` is low, and in the following cycle `busy_o` is low.
- R8: A start pulse that arrives while `busy_o` is high is ignored: the running sequence, its length and its checksum are unchanged, and no second sequence follows.
- R9: The running sum does not wrap for any length value, so the checksum is still correct when both length bytes are 0xFF.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Single-cycle request to format the header |
| length_i | input | 16 | Partition length, sampled on an accepted start |
| wr_en_o | output | 1 | Write strobe to the byte memory |
| wr_addr_o | output | ADDR_W (13) | Byte address of the current write |
| wr_data_o | output | 8 | Byte value of the current write |
| busy_o | output | 1 | High from the cycle after an accepted start until the sequence ends |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Formatting runs with length 0x0000, 0x1234, 0xFFFF and 0x00FF. Zero shows the fixed bytes alone setting the checksum. A mixed value separates the high and low length bytes and catches swapped order. 0xFFFF drives the largest sum and shows whether the accumulator wraps or the carry fold is dropped. During each run `length_i` is changed after start, which shows whether the length is latched. One run pulses start in mid-sequence, and two runs go back to back, to show that a start while busy is ignored while a start straight after idle is accepted.

// File: rtl/nvhdr_pkg.sv
package nvhdr_pkg;

    localparam int unsigned HDR_BYTES = 16;
    localparam int unsigned OFF_W     = $clog2(HDR_BYTES);
    localparam int unsigned CKS_W     = $clog2(HDR_BYTES * 255 + 1);

    localparam logic [7:0] MARK_BYTE = 8'h7F;
    localparam logic [7:0] FILL_BYTE = 8'h77;
    localparam logic [OFF_W-1:0] CKS_OFF  = OFF_W'(1);
    localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(HDR_BYTES - 1);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EMIT,
        ST_PATCH,
        ST_FIN
    } fmt_state_e;

    typedef struct packed {
        logic             en;
        logic [OFF_W-1:0] off;
        logic [7:0]       data;
    } wr_beat_t;

    // Header content by offset; the checksum slot reads as zero here.
    function automatic logic [7:0] hdr_byte(input logic [OFF_W-1:0] off,
                                            input logic [15:0] len);
        logic [7:0] b;
        case (off)
            OFF_W'(0): b = MARK_BYTE;
            OFF_W'(1): b = 8'h00;
            OFF_W'(2): b = len[15:8];
            OFF_W'(3): b = len[7:0];
            default:   b = FILL_BYTE;
        endcase
        return b;
    endfunction

    // End-around-carry fold of the wide sum into one byte.
    function automatic logic [7:0] fold_sum(input logic [CKS_W-1:0] s);
        logic [8:0] t;
        t = 9'(s[7:0]) + 9'(s[CKS_W-1:8]);
        return t[7:0];
    endfunction

endpackage

// File: rtl/nvhdr_seq.sv
module nvhdr_seq
    import nvhdr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [15:0]      length_i,
    output fmt_state_e       state_o,
    output logic [OFF_W-1:0] idx_o,
    output logic [15:0]      len_o,
    output logic             accept_o
);

    fmt_state_e       state_q;
    logic [OFF_W-1:0] idx_q;
    logic [15:0]      len_q;

    assign accept_o = start_i && (state_q == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            len_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept_o) begin
                        state_q <= ST_EMIT;
                        idx_q   <= '0;
                        len_q   <= length_i;
                    end
                end
                ST_EMIT: begin
                    idx_q <= idx_q + OFF_W'(1);
                    if (idx_q == LAST_OFF) state_q <= ST_PATCH;
                end
                ST_PATCH: state_q <= ST_FIN;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    assign state_o = state_q;
    assign idx_o   = idx_q;
    assign len_o   = len_q;

    AST_EMIT_STEP: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_EMIT && idx_q != LAST_OFF)
            |=> (state_q == ST_EMIT && idx_q == $past(idx_q) + OFF_W'(1))); // R2

    AST_LEN_HELD: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE) |=> $stable(len_q)); // R8

    AST_FIN_ONCE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FIN) |=> (state_q == ST_IDLE)); // R7

endmodule

// File: rtl/nvhdr_cksum.sv
module nvhdr_cksum
    import nvhdr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr_i,
    input  logic       add_i,
    input  logic [7:0] byte_i,
    output logic [7:0] cks_o
);

    logic [CKS_W-1:0] acc_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            acc_q <= '0;
        end else if (add_i) begin
            acc_q <= acc_q + CKS_W'(byte_i);
        end
    end

    assign cks_o = fold_sum(acc_q);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (add_i && !clr_i) |=> (acc_q >= $past(acc_q))); // R9

endmodule

// File: rtl/nvhdr_formatter.sv
module nvhdr_formatter
    import nvhdr_pkg::*;
#(
    parameter int unsigned          ADDR_W    = 13,
    parameter logic [ADDR_W-1:0]    BASE_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [15:0]       length_i,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [7:0]        wr_data_o,
    output logic              busy_o,
    output logic              done_o
);

    fmt_state_e       state;
    logic [OFF_W-1:0] idx;
    logic [15:0]      len_q;
    logic             accept;
    logic [7:0]       cur_byte;
    logic [7:0]       cks;
    wr_beat_t         beat;

    nvhdr_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .length_i (length_i),
        .state_o  (state),
        .idx_o    (idx),
        .len_o    (len_q),
        .accept_o (accept)
    );

    assign cur_byte = hdr_byte(idx, len_q);

    nvhdr_cksum u_cksum (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (accept),
        .add_i  (state == ST_EMIT),
        .byte_i (cur_byte),
        .cks_o  (cks)
    );

    always_comb begin
        beat = '0;
        case (state)
            ST_EMIT: begin
                beat.en   = 1'b1;
                beat.off  = idx;
                beat.data = cur_byte;
            end
            ST_PATCH: begin
                beat.en   = 1'b1;
                beat.off  = CKS_OFF;
                beat.data = cks;
            end
            default: beat = '0;
        endcase
    end

    assign wr_en_o   = beat.en;
    assign wr_addr_o = BASE_ADDR + ADDR_W'(beat.off);
    assign wr_data_o = beat.data;
    assign busy_o    = (state != ST_IDLE);
    assign done_o    = (state == ST_FIN);

    AST_PATCH_SLOT: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ($past(wr_en_o) && $past(wr_addr_o) == BASE_ADDR + ADDR_W'(1))); // R6

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> (!done_o && !busy_o)); // R7

    AST_WR_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> (wr_en_o && wr_addr_o == BASE_ADDR)); // R2

endmodule

// File: tb/test_nvhdr_formatter.sv
`timescale 1ns/1ps
module test_nvhdr_formatter;

    localparam int AW = 13;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [15:0]   length = '0;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [7:0]    wr_data;
    logic          busy;
    logic          done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    nvhdr_formatter #(.ADDR_W(AW)) i_nvhdr_formatter (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start),
        .length_i  (length),
        .wr_en_o   (wr_en),
        .wr_addr_o (wr_addr),
        .wr_data_o (wr_data),
        .busy_o    (busy),
        .done_o    (done)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(input int off, input logic [15:0] len);
        if (off == 0) return 8'h7F;
        if (off == 1) return 8'h00;
        if (off == 2) return len[15:8];
        if (off == 3) return len[7:0];
        return 8'h77;
    endfunction

    function automatic logic [7:0] exp_cks(input logic [15:0] len);
        int s = 0;
        int f;
        for (int i = 0; i < 16; i++) s += exp_byte(i, len);
        f = (s & 255) + (s >> 8);
        return 8'(f);
    endfunction

    task automatic test_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", "wr_en after reset", 32'(wr_en), 0);
        chk("R1", "done after reset", 32'(done), 0);
        chk("R1", "busy after reset", 32'(busy), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "wr_en idle", 32'(wr_en), 0);
    endtask

    task automatic run_format(input logic [15:0] len, input bit poke);
        string rq;
        @(negedge clk);
        start  = 1'b1;
        length = len;
        @(negedge clk);
        start  = 1'b0;
        length = len ^ 16'hA5A5;
        for (int c = 0; c < 19; c++) begin
            if (c > 0) @(negedge clk);
            if (c < 16) begin
                rq = (c < 2) ? "R3" : (c < 4) ? "R4" : "R5";
                chk("R2", $sformatf("wr_en beat %0d", c), 32'(wr_en), 1);
                chk("R2", $sformatf("addr beat %0d", c), 32'(wr_addr), 32'(c));
                chk(rq, $sformatf("data off %0d len %h", c, len), 32'(wr_data),
                    32'(exp_byte(c, len)));
            end else if (c == 16) begin
                chk("R6", "patch wr_en", 32'(wr_en), 1);
                chk("R6", "patch addr", 32'(wr_addr), 1);
                chk((len == 16'hFFFF) ? "R9" : "R6", $sformatf("checksum len %h", len),
                    32'(wr_data), 32'(exp_cks(len)));
            end else if (c == 17) begin
                chk("R7", "done pulse", 32'(done), 1);
                chk("R7", "no write with done", 32'(wr_en), 0);
            end else begin
                chk("R7", "done dropped", 32'(done), 0);
                chk(poke ? "R8" : "R7", "busy dropped", 32'(busy), 0);
                chk(poke ? "R8" : "R7", "no further write", 32'(wr_en), 0);
            end
            if (poke && c == 5) begin
                start  = 1'b1;
                length = 16'h5A5A;
            end else begin
                start = 1'b0;
            end
        end
        if (poke) begin
            @(negedge clk);
            chk("R8", "no restart after ignored start", 32'(busy), 0);
        end
    endtask

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        test_reset();
        run_format(16'h0000, 1'b0);
        run_format(16'h1234, 1'b0);
        run_format(16'hFFFF, 1'b0);
        run_format(16'h00FF, 1'b1);
        run_format(16'h8001, 1'b0);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule